// File: doc/BRIEF.md
# Transmit Audio Interrupt Controller

This block sits beside a transmit audio FIFO and turns its raw condition flags into interrupt status. Three interrupt causes are formed: an underrun cause from a sticky flag that the FIFO sets with a one-cycle event pulse, a refill cause that tracks the FIFO half-empty flag, and a completion cause that is true while the channel is idle and the FIFO holds nothing. Each cause is gated by an enable bit in a mask register, and the gated causes are ORed into one level-sensitive interrupt line.

Software reaches the block through a small register port with a write strobe, a 2-bit address and a combinational read path. It can program the mask, read the raw flags, read the interrupt status, and write a clear register to drop the sticky underrun flag once it has been serviced.

Register map (address on `reg_addr_i`): 0 = mask (read/write, bits 6:0), 1 = raw flags (read-only: bit 0 sticky underrun, bit 1 half-empty, bit 2 busy, bit 3 empty), 2 = interrupt status (read-only), 3 = clear (write-only, reads zero). Interrupt status bit positions: bit 0 completion, bit 1 refill, bit 2 underrun; bits 6:3 read zero.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the raw flags show the sticky underrun flag clear, and `irq_o` is low.
- R2: A cycle with `underrun_evt_i` high sets the sticky underrun flag from the next cycle on; interrupt status bit 2 equals that flag.
- R3: A write to address 3 with bit 0 set clears the sticky underrun flag; a write to address 3 with bit 0 clear leaves it unchanged.
- R4: When a clear write and an underrun event fall in the same cycle, the sticky underrun flag is set afterwards.
- R5: Interrupt status bit 1 equals `half_empty_i` in every cycle.
- R6: Interrupt status bit 0 is 1 exactly when `busy_i` is 0 and `empty_i` is 1.
- R7: `irq_o` is registered: it equals the OR of (interrupt status AND mask) as it stood in the previous cycle, so a status or mask change reaches `irq_o` one cycle later.
- R8: A write to address 0 stores bits 6:0 of the write data as the mask; bits 31:7 are ignored and read back as 0.
- R9: A read of address 2 returns only the low 7 bits of interrupt status; bits 31:7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| underrun_evt_i | input | 1 | One-cycle underrun event from the FIFO |
| half_empty_i | input | 1 | FIFO at or below half full |
| busy_i | input | 1 | Channel is transmitting |
| empty_i | input | 1 | FIFO holds no samples |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
The hardest case to reach is a clear write that lands in the very cycle the FIFO reports a fresh underrun, because the event is a single-cycle pulse and the write is a separate transaction. The bench drives both inputs from one task on the same falling edge so that a single rising edge captures both, then reads the raw flags to see the flag survive. The one-cycle interrupt latency is checked by sampling `irq_o` just before and just after the edge that follows a flag or mask change.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int ADDR_W  = 2;
  localparam int ISTAT_W = 7;

  localparam logic [ADDR_W-1:0] REG_MASK  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_FLAGS = 2'd1;
  localparam logic [ADDR_W-1:0] REG_ISTAT = 2'd2;
  localparam logic [ADDR_W-1:0] REG_CLEAR = 2'd3;

  localparam int IB_TXC = 0;
  localparam int IB_TX  = 1;
  localparam int IB_UR  = 2;

  localparam int CLR_UR = 0;
endpackage

// File: rtl/ur_sticky.sv
module ur_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i) |=> flag_q);
endmodule

// File: rtl/istat_build.sv
module istat_build
  import audio_irq_pkg::*;
(
  input  logic               ur_i,
  input  logic               half_empty_i,
  input  logic               busy_i,
  input  logic               empty_i,
  output logic [ISTAT_W-1:0] istat_o
);
  always_comb begin
    istat_o         = '0;
    istat_o[IB_UR]  = ur_i;
    istat_o[IB_TX]  = half_empty_i;
    istat_o[IB_TXC] = !busy_i && empty_i;
  end
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [W-1:0] istat_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(istat_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r8_mask_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_q);
  a_r7_no_cause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_i == '0) |=> !irq_q);
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              underrun_evt_i,
  input  logic              half_empty_i,
  input  logic              busy_i,
  input  logic              empty_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int FLAG_W = 4;

  logic               ur_flag;
  logic               ur_clr;
  logic               mask_we;
  logic [ISTAT_W-1:0] istat;
  logic [ISTAT_W-1:0] mask;
  logic [FLAG_W-1:0]  flags;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:ISTAT_W];

  assign mask_we = reg_we_i && (reg_addr_i == REG_MASK);
  assign ur_clr  = reg_we_i && (reg_addr_i == REG_CLEAR) && reg_wdata_i[CLR_UR];

  ur_sticky u_ur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (underrun_evt_i),
    .clr_i  (ur_clr),
    .flag_o (ur_flag)
  );

  istat_build u_stat (
    .ur_i         (ur_flag),
    .half_empty_i (half_empty_i),
    .busy_i       (busy_i),
    .empty_i      (empty_i),
    .istat_o      (istat)
  );

  irq_mask #(.W(ISTAT_W)) u_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i[ISTAT_W-1:0]),
    .istat_i      (istat),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  assign flags = {empty_i, busy_i, half_empty_i, ur_flag};

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_MASK:  reg_rdata_o = {{(DATA_W-ISTAT_W){1'b0}}, mask};
      REG_FLAGS: reg_rdata_o = {{(DATA_W-FLAG_W){1'b0}}, flags};
      REG_ISTAT: reg_rdata_o = {{(DATA_W-ISTAT_W){1'b0}}, istat};
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r5_tx_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat[IB_TX] == half_empty_i);
  a_r6_txc_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat[IB_TXC] == (!busy_i && empty_i));
  a_r2_ur_bit_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat[IB_UR] == ur_flag);
  a_r9_istat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_ISTAT) |-> (reg_rdata_o[DATA_W-1:ISTAT_W] == '0));
endmodule

// File: tb/tb_audio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_audio_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        evt = 0, half = 0, busy = 1, empty = 0;
  logic        we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .underrun_evt_i(evt), .half_empty_i(half),
    .busy_i(busy), .empty_i(empty), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  // drive at negedge, captured by next posedge, return at next negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; wdata = 0;
  endtask

  task automatic pulse_evt();
    evt = 1; @(negedge clk); evt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 mask", d, 32'h0);
    rd(2'd1, d); chk("R1 flag", d[0], 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    pulse_evt();
    rd(2'd1, d); chk("R2 flag set", d[0], 1'b1);
    rd(2'd2, d); chk("R2 istat bit2", d[2], 1'b1);
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd1, d); chk("R3 clear bit0=0 keeps", d[0], 1'b1);
    wr(2'd3, 32'h1);
    rd(2'd1, d); chk("R3 clear drops", d[0], 1'b0);
    rd(2'd2, d); chk("R2 istat bit2 low", d[2], 1'b0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    evt = 1; we = 1; addr = 2'd3; wdata = 32'h1;
    @(negedge clk);
    evt = 0; we = 0; wdata = 0;
    rd(2'd1, d); chk("R4 set wins", d[0], 1'b1);
    wr(2'd3, 32'h1);
    rd(2'd1, d); chk("R4 cleared after", d[0], 1'b0);
  endtask

  task automatic t_tx_txc();
    logic [31:0] d;
    half = 1; rd(2'd2, d); chk("R5 bit1 high", d[1], 1'b1);
    half = 0; rd(2'd2, d); chk("R5 bit1 low", d[1], 1'b0);
    busy = 1; empty = 1; rd(2'd2, d); chk("R6 busy empty", d[0], 1'b0);
    busy = 0; empty = 0; rd(2'd2, d); chk("R6 idle notempty", d[0], 1'b0);
    busy = 0; empty = 1; rd(2'd2, d); chk("R6 idle empty", d[0], 1'b1);
    busy = 1; empty = 0; @(negedge clk);
  endtask

  task automatic t_irq();
    wr(2'd0, 32'h1);             // enable completion
    chk("R7 masked cause quiet", irq, 1'b0);
    busy = 0; empty = 1; #0.5;
    chk("R7 before edge", irq, 1'b0);
    @(negedge clk);
    chk("R7 after edge", irq, 1'b1);
    we = 1; addr = 2'd0; wdata = 32'h2;  // move mask to refill
    @(negedge clk); we = 0; wdata = 0;
    chk("R7 mask change one cycle", irq, 1'b1);
    @(negedge clk);
    chk("R7 masked off", irq, 1'b0);
    half = 1; @(negedge clk);
    chk("R7 refill raises", irq, 1'b1);
    half = 0; busy = 1; empty = 0;
    wr(2'd0, 32'h4);
    pulse_evt();
    chk("R7 ur not yet", irq, 1'b0);
    @(negedge clk);
    chk("R7 ur raises", irq, 1'b1);
    wr(2'd3, 32'h1);
    @(negedge clk);
    chk("R7 ur cleared", irq, 1'b0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R8 mask 7 bits", d, 32'h7F);
    wr(2'd0, 32'hABCD_EF00);
    rd(2'd0, d); chk("R8 mask upper ignored", d, 32'h0);
    half = 1; busy = 0; empty = 1; pulse_evt();
    rd(2'd2, d); chk("R9 istat low 7", d, 32'h7);
    rd(2'd3, d); chk("R9 clear reads 0", d, 32'h0);
    wr(2'd3, 32'h1);
    half = 0; busy = 1; empty = 0;
  endtask

  initial begin
    #1000000;
    n_fail++; n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_underrun();
    t_collide();
    t_tx_txc();
    t_irq();
    t_regs();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule